// File: doc/BRIEF.md
# HID Report Register Bank with Button Debounce

This block holds the four-byte output report and assembles the four-byte input report that a host exchanges with an audio device over its HID interrupt pipe. A two-bit mode field at the top of output byte 0 selects what the other output bytes mean. In GPIO mode they set four general-purpose pins and the S/PDIF channel-status fields. In EEPROM mode they load the data and control registers of an external EEPROM sequencer. The input report follows the same mode, carrying either GPIO pin levels or the read-back data of the sequencer.

Four active-low buttons (volume up, volume down, playback mute, record mute) each pass through a synchronizer and a debounce filter. The volume buttons appear in the input report as live held levels. The two mute buttons appear as latched press-then-release events that clear once the endpoint accepts the report. Each accepted record-mute event toggles a record-mute state, which drives an LED. The block raises an interrupt-report request whenever the input report changes, and also when the EEPROM sequencer reports that an access has completed. The USB endpoint engine, the S/PDIF encoder and the EEPROM sequencer are separate blocks and connect through plain ports.

Top module: `hid_report_ctrl`

## Requirements
- R1: After reset, the input report, all GPIO drive and direction bits, the S/PDIF fields, the EEPROM register outputs, `irq_req` and `rec_led` are all zero.
- R2: A write to output byte 0 always stores bits [7:6] as the mode. Input report bits [7:6] read `10` when mode bit 7 is set, and read `00` otherwise.
- R3: In mode `00`, output byte 1 bits [3:0] set `gpio_out` and output byte 2 bits [3:0] set `gpio_oe`. Bit i controls pin i, and a 1 in `gpio_oe` means the pin drives. Both outputs change only in the cycle after a write.
- R4: A write to byte 0 whose new mode is `00` loads bit 4 into `spdif_valid` and bits [3:0] into `spdif_cs_nib`. A write to byte 3 in mode `00` loads `spdif_category`. Writes to byte 0 that carry any other mode leave the S/PDIF fields unchanged.
- R5: In modes `10` and `11`, writes to bytes 1, 2 and 3 load `ee_data0_o`, `ee_data1_o` and `ee_ctrl_o`. A write to byte 3 also pulses `ee_start` high for the next cycle. Input report bytes 1, 2 and 3 (report bits [15:8], [23:16], [31:24]) show `ee_data0_i`, `ee_data1_i` and `ee_ctrl_i`.
- R6: In mode `01`, writes to bytes 1 to 3 are ignored, and so are bits [4:0] of a byte 0 write that carries mode `01`.
- R7: Outside EEPROM mode, input report byte 1 bits [3:0] carry the synchronized `gpio_in` level of each pin whose direction bit is 0 and read 0 for pins set to drive. Input report byte 1 bits [7:4], byte 2 and byte 3 read zero.
- R8: A button's debounced state changes only after its pin has held the new level for `DEB_CYCLES` clocks after synchronization. A pulse shorter than that has no effect.
- R9: Input report bit 0 is 1 while volume-up is held (debounced pin low), and bit 1 is 1 while volume-down is held.
- R10: Input report bit 2 (playback mute) and bit 3 (record mute) set on the debounced release that follows a press. Each clears on `rpt_ack` unless a new release arrives in the same cycle.
- R11: The record-mute state toggles on each `rpt_ack` given while bit 3 is set, and `rec_led` equals that state.
- R12: `irq_req` sets one cycle after any input report bit changes, or after an `ee_done` pulse. Clearing of event bits by `rpt_ack` does not set it. It clears on `rpt_ack` when no new cause arrives.
- R13: GPIO drive, direction and S/PDIF settings are kept while the mode is `01`, `10` or `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_n | input | 4 | Buttons, active low: [0] vol up, [1] vol down, [2] playback mute, [3] record mute |
| out_wr | input | 1 | Write strobe for one output report byte |
| out_addr | input | 2 | Output report byte index |
| out_data | input | 8 | Output report byte value |
| rpt_ack | input | 1 | Endpoint accepted the current input report |
| in_report | output | 32 | Input report, byte 0 in bits [7:0] |
| irq_req | output | 1 | Interrupt-report request |
| gpio_in | input | 4 | GPIO pin levels (asynchronous) |
| gpio_out | output | 4 | GPIO drive values |
| gpio_oe | output | 4 | GPIO output enables |
| spdif_valid | output | 1 | S/PDIF validity bit |
| spdif_cs_nib | output | 4 | First channel-status nibble |
| spdif_category | output | 8 | Channel-status category byte |
| ee_data0_o | output | 8 | EEPROM data register 0 |
| ee_data1_o | output | 8 | EEPROM data register 1 |
| ee_ctrl_o | output | 8 | EEPROM control register |
| ee_start | output | 1 | One-cycle pulse after an EEPROM control write |
| ee_data0_i | input | 8 | EEPROM read-back data 0 |
| ee_data1_i | input | 8 | EEPROM read-back data 1 |
| ee_ctrl_i | input | 8 | EEPROM read-back status |
| ee_done | input | 1 | EEPROM access completed |
| rec_led | output | 1 | High while recording is muted |

## Verification
The bench stimulates the button filter with pulses shorter than the debounce window and checks that none is accepted. A filter that resets its counter wrongly would report phantom presses, or never report real ones. After an event has been acknowledged, the bench checks that the request line stays low. A design that counts that clearing as a report change would ask the host for an endless series of reports. The reserved mode and the EEPROM modes both receive writes. A decoder that ignores the mode would clobber GPIO pins or the S/PDIF category through bytes meant for the sequencer. Random GPIO and S/PDIF writes, combined with random pin levels, compare the masking of pins set to drive against a model kept in the bench.

// File: rtl/hid_rpt_pkg.sv
package hid_rpt_pkg;

  localparam int NUM_BTN  = 4;
  localparam int NUM_GPIO = 4;

  localparam int BTN_VUP   = 0;
  localparam int BTN_VDN   = 1;
  localparam int BTN_PMUTE = 2;
  localparam int BTN_RMUTE = 3;

  typedef enum logic [1:0] {
    MODE_GPIO   = 2'b00,
    MODE_RSV    = 2'b01,
    MODE_EE     = 2'b10,
    MODE_EE_ALT = 2'b11
  } rpt_mode_e;

  // modes with the top bit set route bytes 1..3 to the EEPROM registers
  function automatic logic mode_is_ee(input logic [1:0] m);
    return m[1];
  endfunction

  // status byte: mode tag, reserved zeros, two events, two live levels
  function automatic logic [7:0] status_byte(input logic ee, input logic rec_evt,
                                             input logic play_evt, input logic vdn,
                                             input logic vup);
    return {ee, 1'b0, 2'b00, rec_evt, play_evt, vdn, vup};
  endfunction

  // pins set to drive read as zero in the report
  function automatic logic [7:0] gpio_byte(input logic [NUM_GPIO-1:0] lvl,
                                           input logic [NUM_GPIO-1:0] dir);
    return {{(8-NUM_GPIO){1'b0}}, lvl & ~dir};
  endfunction

  // falling event bits come only from acknowledgement; they never request a report
  function automatic logic [31:0] evt_fall_mask(input logic [31:0] prev,
                                                input logic [31:0] cur);
    logic [31:0] m;
    m = '0;
    m[BTN_PMUTE] = prev[BTN_PMUTE] & ~cur[BTN_PMUTE];
    m[BTN_RMUTE] = prev[BTN_RMUTE] & ~cur[BTN_RMUTE];
    return m;
  endfunction

endpackage

// File: rtl/hid_btn_debounce.sv
module hid_btn_debounce #(
  parameter int unsigned DEB_CYCLES = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pressed,
  output logic release_p
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic          s1, s2, stable;
  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = (s2 != stable) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      stable <= 1'b1;
      cnt    <= '0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      if (s2 == stable) begin
        cnt <= '0;
      end else if (accept) begin
        stable <= s2;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pressed   = ~stable;
  assign release_p = accept & s2;
endmodule

// File: rtl/hid_out_bank.sv
module hid_out_bank
  import hid_rpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [7:0]          data,
  output logic [1:0]          mode,
  output logic [NUM_GPIO-1:0] gpio_drv,
  output logic [NUM_GPIO-1:0] gpio_dir,
  output logic                spdif_valid,
  output logic [3:0]          spdif_nib,
  output logic [7:0]          spdif_cat,
  output logic [7:0]          ee_d0,
  output logic [7:0]          ee_d1,
  output logic [7:0]          ee_ctl,
  output logic                ee_start
);
  logic       wr0, wr1, wr2, wr3;
  logic       cur_gpio, cur_ee;
  logic [1:0] new_mode;

  assign wr0      = wr && (addr == 2'd0);
  assign wr1      = wr && (addr == 2'd1);
  assign wr2      = wr && (addr == 2'd2);
  assign wr3      = wr && (addr == 2'd3);
  assign cur_gpio = (mode == MODE_GPIO);
  assign cur_ee   = mode_is_ee(mode);
  assign new_mode = data[7:6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode        <= MODE_GPIO;
      gpio_drv    <= '0;
      gpio_dir    <= '0;
      spdif_valid <= 1'b0;
      spdif_nib   <= '0;
      spdif_cat   <= '0;
      ee_d0       <= '0;
      ee_d1       <= '0;
      ee_ctl      <= '0;
      ee_start    <= 1'b0;
    end else begin
      ee_start <= 1'b0;
      if (wr0) begin
        mode <= new_mode;
        if (new_mode == MODE_GPIO) begin
          spdif_valid <= data[4];
          spdif_nib   <= data[3:0];
        end
      end
      if (wr1) begin
        if (cur_gpio)    gpio_drv <= data[NUM_GPIO-1:0];
        else if (cur_ee) ee_d0    <= data;
      end
      if (wr2) begin
        if (cur_gpio)    gpio_dir <= data[NUM_GPIO-1:0];
        else if (cur_ee) ee_d1    <= data;
      end
      if (wr3) begin
        if (cur_gpio) begin
          spdif_cat <= data;
        end else if (cur_ee) begin
          ee_ctl   <= data;
          ee_start <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hid_in_report.sv
module hid_in_report
  import hid_rpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                vup_lvl,
  input  logic                vdn_lvl,
  input  logic                play_rel_p,
  input  logic                rec_rel_p,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_GPIO-1:0] gpio_dir,
  input  logic [7:0]          ee_d0_i,
  input  logic [7:0]          ee_d1_i,
  input  logic [7:0]          ee_ctl_i,
  input  logic                ee_done,
  input  logic                rpt_ack,
  output logic [31:0]         report,
  output logic                irq_req,
  output logic                rec_muted,
  output logic                rpt_changed
);
  logic [NUM_GPIO-1:0] g1, g2;
  logic                play_evt, rec_evt;
  logic [31:0]         prev;
  logic                ee_sel;

  assign ee_sel = mode_is_ee(mode);

  always_comb begin
    report[7:0]   = status_byte(ee_sel, rec_evt, play_evt, vdn_lvl, vup_lvl);
    report[15:8]  = ee_sel ? ee_d0_i  : gpio_byte(g2, gpio_dir);
    report[23:16] = ee_sel ? ee_d1_i  : 8'h00;
    report[31:24] = ee_sel ? ee_ctl_i : 8'h00;
  end

  assign rpt_changed = |((report ^ prev) & ~evt_fall_mask(prev, report));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g1        <= '0;
      g2        <= '0;
      play_evt  <= 1'b0;
      rec_evt   <= 1'b0;
      rec_muted <= 1'b0;
      prev      <= '0;
      irq_req   <= 1'b0;
    end else begin
      g1        <= gpio_in;
      g2        <= g1;
      play_evt  <= (play_evt & ~rpt_ack) | play_rel_p;
      rec_evt   <= (rec_evt & ~rpt_ack) | rec_rel_p;
      rec_muted <= rec_muted ^ (rpt_ack & rec_evt);
      prev      <= report;
      irq_req   <= (irq_req & ~rpt_ack) | rpt_changed | ee_done;
    end
  end
endmodule

// File: rtl/hid_report_ctrl.sv
module hid_report_ctrl
  import hid_rpt_pkg::*;
#(
  parameter int unsigned CLK_HZ = 12000000,
  parameter int unsigned DEB_MS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  btn_n,
  input  logic        out_wr,
  input  logic [1:0]  out_addr,
  input  logic [7:0]  out_data,
  input  logic        rpt_ack,
  output logic [31:0] in_report,
  output logic        irq_req,
  input  logic [3:0]  gpio_in,
  output logic [3:0]  gpio_out,
  output logic [3:0]  gpio_oe,
  output logic        spdif_valid,
  output logic [3:0]  spdif_cs_nib,
  output logic [7:0]  spdif_category,
  output logic [7:0]  ee_data0_o,
  output logic [7:0]  ee_data1_o,
  output logic [7:0]  ee_ctrl_o,
  output logic        ee_start,
  input  logic [7:0]  ee_data0_i,
  input  logic [7:0]  ee_data1_i,
  input  logic [7:0]  ee_ctrl_i,
  input  logic        ee_done,
  output logic        rec_led
);
  localparam int unsigned DEB_RAW    = (CLK_HZ / 1000) * DEB_MS;
  localparam int unsigned DEB_CYCLES = (DEB_RAW < 2) ? 2 : DEB_RAW;

  logic [NUM_BTN-1:0]  btn_pressed_w;
  logic [NUM_BTN-1:0]  btn_release_w;
  logic [1:0]          mode_w;
  logic [NUM_GPIO-1:0] gpio_dir_w;
  logic                rpt_changed_w;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    hid_btn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (btn_n[b]),
      .pressed   (btn_pressed_w[b]),
      .release_p (btn_release_w[b])
    );
  end

  hid_out_bank u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (out_wr),
    .addr        (out_addr),
    .data        (out_data),
    .mode        (mode_w),
    .gpio_drv    (gpio_out),
    .gpio_dir    (gpio_dir_w),
    .spdif_valid (spdif_valid),
    .spdif_nib   (spdif_cs_nib),
    .spdif_cat   (spdif_category),
    .ee_d0       (ee_data0_o),
    .ee_d1       (ee_data1_o),
    .ee_ctl      (ee_ctrl_o),
    .ee_start    (ee_start)
  );

  assign gpio_oe = gpio_dir_w;

  hid_in_report u_in (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_w),
    .vup_lvl     (btn_pressed_w[BTN_VUP]),
    .vdn_lvl     (btn_pressed_w[BTN_VDN]),
    .play_rel_p  (btn_release_w[BTN_PMUTE]),
    .rec_rel_p   (btn_release_w[BTN_RMUTE]),
    .gpio_in     (gpio_in),
    .gpio_dir    (gpio_dir_w),
    .ee_d0_i     (ee_data0_i),
    .ee_d1_i     (ee_data1_i),
    .ee_ctl_i    (ee_ctrl_i),
    .ee_done     (ee_done),
    .rpt_ack     (rpt_ack),
    .report      (in_report),
    .irq_req     (irq_req),
    .rec_muted   (rec_led),
    .rpt_changed (rpt_changed_w)
  );
endmodule

// File: rtl/hid_report_ctrl_chk.sv
module hid_report_ctrl_chk #(
  parameter int unsigned DEB_CYCLES = 120000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  btn_n,
  input logic        out_wr,
  input logic [1:0]  out_addr,
  input logic        rpt_ack,
  input logic [31:0] in_report,
  input logic        irq_req,
  input logic [3:0]  gpio_oe,
  input logic [3:0]  gpio_out,
  input logic        ee_start,
  input logic        ee_done,
  input logic        rec_led,
  input logic [3:0]  btn_pressed,
  input logic [3:0]  btn_release
);
  logic [31:0] rep_d;
  always_ff @(posedge clk) begin
    if (!rst_n) rep_d <= '0;
    else        rep_d <= in_report;
  end

  // R3
  gpio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_wr) |-> ($stable(gpio_oe) && $stable(gpio_out)));

  // R5
  ee_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_start |-> $past(out_wr && (out_addr == 2'd3) && in_report[7]));

  // R10
  play_evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_report[2]) |-> $past(btn_release[2]));

  // R10
  rec_evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_ack && in_report[3] && !btn_release[3]) |=> !in_report[3]);

  // R11
  led_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_led) |-> $past(rpt_ack && in_report[3]));

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(ee_done) || ($past(in_report) != $past(rep_d))));

  // R12
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_ack && !ee_done && (in_report == rep_d)) |=> !irq_req);

  for (genvar b = 0; b < 4; b++) begin : g_deb
    logic        pin_q;
    logic [31:0] hold_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_q    <= 1'b1;
        hold_cnt <= '0;
      end else begin
        pin_q <= btn_n[b];
        if (btn_n[b] != pin_q)         hold_cnt <= '0;
        else if (hold_cnt < DEB_CYCLES + 4) hold_cnt <= hold_cnt + 1;
      end
    end
    // R8
    debounce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(btn_pressed[b]) |-> (hold_cnt >= DEB_CYCLES));
  end
endmodule

bind hid_report_ctrl hid_report_ctrl_chk #(.DEB_CYCLES(DEB_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .btn_n       (btn_n),
  .out_wr      (out_wr),
  .out_addr    (out_addr),
  .rpt_ack     (rpt_ack),
  .in_report   (in_report),
  .irq_req     (irq_req),
  .gpio_oe     (gpio_oe),
  .gpio_out    (gpio_out),
  .ee_start    (ee_start),
  .ee_done     (ee_done),
  .rec_led     (rec_led),
  .btn_pressed (btn_pressed_w),
  .btn_release (btn_release_w)
);

// File: tb/hid_report_ctrl_test.sv
module hid_report_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  btn_n = 4'hF;
  logic        out_wr = 1'b0;
  logic [1:0]  out_addr = 2'd0;
  logic [7:0]  out_data = 8'h00;
  logic        rpt_ack = 1'b0;
  logic [31:0] in_report;
  logic        irq_req;
  logic [3:0]  gpio_in = 4'h0;
  logic [3:0]  gpio_out, gpio_oe;
  logic        spdif_valid;
  logic [3:0]  spdif_cs_nib;
  logic [7:0]  spdif_category;
  logic [7:0]  ee_data0_o, ee_data1_o, ee_ctrl_o;
  logic        ee_start;
  logic [7:0]  ee_data0_i = 8'h00, ee_data1_i = 8'h00, ee_ctrl_i = 8'h00;
  logic        ee_done = 1'b0;
  logic        rec_led;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] m_drv = 4'h0, m_dir = 4'h0, m_nib = 4'h0;
  logic       m_val = 1'b0;
  logic [7:0] m_cat = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  hid_report_ctrl #(.CLK_HZ(100000), .DEB_MS(1)) uut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .out_wr(out_wr), .out_addr(out_addr),
    .out_data(out_data), .rpt_ack(rpt_ack), .in_report(in_report), .irq_req(irq_req),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .spdif_valid(spdif_valid),
    .spdif_cs_nib(spdif_cs_nib), .spdif_category(spdif_category), .ee_data0_o(ee_data0_o),
    .ee_data1_o(ee_data1_o), .ee_ctrl_o(ee_ctrl_o), .ee_start(ee_start),
    .ee_data0_i(ee_data0_i), .ee_data1_i(ee_data1_i), .ee_ctrl_i(ee_ctrl_i),
    .ee_done(ee_done), .rec_led(rec_led)
  );

  function automatic logic [7:0] exp_pin_byte(input logic [3:0] lvl, input logic [3:0] dir);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 4; i++) r[i] = dir[i] ? 1'b0 : lvl[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    out_wr = 1'b1; out_addr = a; out_data = d;
    @(negedge clk);
    out_wr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rpt_ack = 1'b1;
    @(negedge clk); rpt_ack = 1'b0;
    cyc(2);
  endtask

  task automatic tap(input int b);
    btn_n[b] = 1'b0; cyc(DEB + 20);
    btn_n[b] = 1'b1; cyc(DEB + 20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 report", in_report, 32'h0);
    chk("R1 gpio", {gpio_out, gpio_oe}, 8'h00);
    chk("R1 spdif", {spdif_valid, spdif_cs_nib, spdif_category}, 13'h0);
    chk("R1 ee", {ee_data0_o, ee_data1_o, ee_ctrl_o, ee_start}, 25'h0);
    chk("R1 irq/led", {irq_req, rec_led}, 2'b00);

    // R3 / R4 directed
    wr(2'd1, 8'hA5); m_drv = 4'h5;
    chk("R3 drive", gpio_out, 4'h5);
    wr(2'd2, 8'hF3); m_dir = 4'h3;
    chk("R3 dir", gpio_oe, 4'h3);
    wr(2'd0, 8'h1B); m_val = 1'b1; m_nib = 4'hB;
    chk("R4 valid/nib", {spdif_valid, spdif_cs_nib}, 5'h1B);
    wr(2'd3, 8'h82); m_cat = 8'h82;
    chk("R4 category", spdif_category, 8'h82);

    // R7 pin levels, masked by direction
    gpio_in = 4'b1010; cyc(4);
    chk("R7 byte1", in_report[15:8], 8'h08);
    chk("R7 bytes2-3", in_report[31:16], 16'h0);
    chk("R12 irq on change", irq_req, 1'b1);
    ack();
    chk("R12 irq cleared", irq_req, 1'b0);

    // random GPIO / S/PDIF traffic
    for (int it = 0; it < 150; it++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(3, 0));
      d = 8'($urandom);
      if (a == 2'd0) d[7:6] = 2'b00;
      wr(a, d);
      case (a)
        2'd0: begin m_val = d[4]; m_nib = d[3:0]; end
        2'd1: m_drv = d[3:0];
        2'd2: m_dir = d[3:0];
        default: m_cat = d;
      endcase
      gpio_in = 4'($urandom);
      cyc(3);
      chk("R3 random", {gpio_out, gpio_oe}, {m_drv, m_dir});
      chk("R4 random", {spdif_valid, spdif_cs_nib, spdif_category}, {m_val, m_nib, m_cat});
      chk("R7 random", in_report[15:8], exp_pin_byte(gpio_in, m_dir));
    end
    ack();

    // R6 reserved mode ignores writes
    wr(2'd0, 8'h5F);
    chk("R6 spdif kept", {spdif_valid, spdif_cs_nib}, {m_val, m_nib});
    chk("R2 mode 01 tag", in_report[7:6], 2'b00);
    wr(2'd1, ~{4'h0, m_drv}); wr(2'd2, ~{4'h0, m_dir}); wr(2'd3, ~m_cat);
    chk("R6 gpio kept", {gpio_out, gpio_oe}, {m_drv, m_dir});
    chk("R6 cat kept", spdif_category, m_cat);
    chk("R6 ee untouched", {ee_data0_o, ee_data1_o, ee_ctrl_o}, 24'h0);

    // R5 EEPROM mode
    wr(2'd0, 8'h9F);
    chk("R2 mode 10 tag", in_report[7:6], 2'b10);
    chk("R4 spdif kept in ee", {spdif_valid, spdif_cs_nib}, {m_val, m_nib});
    wr(2'd1, 8'h3C); wr(2'd2, 8'hC3);
    chk("R13 gpio kept in ee", {gpio_out, gpio_oe}, {m_drv, m_dir});
    chk("R5 ee data", {ee_data0_o, ee_data1_o}, 16'h3CC3);
    chk("R5 no start on data", ee_start, 1'b0);
    wr(2'd3, 8'h5A);
    chk("R5 start pulse", {ee_start, ee_ctrl_o}, 9'h15A);
    cyc(1);
    chk("R5 start ends", ee_start, 1'b0);
    chk("R5 cat kept", spdif_category, m_cat);
    ee_data0_i = 8'h11; ee_data1_i = 8'h22; ee_ctrl_i = 8'h33; cyc(1);
    chk("R5 readback", in_report[31:8], 24'h332211);
    ack();
    chk("R12 quiet", irq_req, 1'b0);
    @(negedge clk); ee_done = 1'b1; @(negedge clk); ee_done = 1'b0; cyc(1);
    chk("R12 ee_done", irq_req, 1'b1);
    ack();
    wr(2'd0, 8'hC0); wr(2'd1, 8'h77);
    chk("R5 mode 11", ee_data0_o, 8'h77);
    chk("R2 mode 11 tag", in_report[7:6], 2'b10);
    wr(2'd0, {3'b000, m_val, m_nib});
    gpio_in = 4'h0; cyc(4);
    ack();

    // R8 / R9 volume levels
    btn_n[0] = 1'b0; cyc(DEB / 2);
    chk("R8 not yet", in_report[0], 1'b0);
    cyc(DEB / 2 + 10);
    chk("R9 vol up held", in_report[1:0], 2'b01);
    btn_n[1] = 1'b0; cyc(DEB + 10);
    chk("R9 both held", in_report[1:0], 2'b11);
    btn_n[1:0] = 2'b11; cyc(DEB + 10);
    chk("R9 released", in_report[1:0], 2'b00);
    ack();
    btn_n[1] = 1'b0; cyc(DEB * 4 / 10); btn_n[1] = 1'b1; cyc(DEB + 50);
    chk("R8 glitch ignored", {irq_req, in_report[7:0]}, 9'h000);

    // R10 / R11 / R12 mute events
    tap(2);
    chk("R10 play event", in_report[3:2], 2'b01);
    chk("R12 irq event", irq_req, 1'b1);
    ack();
    chk("R10 play cleared", in_report[2], 1'b0);
    chk("R12 clear no irq", irq_req, 1'b0);
    tap(3);
    chk("R10 rec event", in_report[3], 1'b1);
    chk("R11 led before ack", rec_led, 1'b0);
    ack();
    chk("R11 led muted", {rec_led, in_report[3]}, 2'b10);
    tap(3); ack();
    chk("R11 led unmuted", rec_led, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule